// File: doc/BRIEF.md
# Minifloat to Single-Precision Expander

This block widens a compact floating-point code into a 32-bit IEEE single-precision word. The compact code has one sign bit, an exponent field of `EXP_W` bits and a fraction field of `MAN_W` bits. Its bias is 2^(EXP_W-1)-1. Single precision has more exponent range and more fraction bits than any supported code, so every finite input value comes out exact and no rounding logic exists.

Each input is sorted into one of five classes: zero, subnormal, normal, infinity or not-a-number. Normal inputs take the new bias and have their fraction left-aligned. A subnormal input has a leading-one search on its fraction field. The position found sets two things: how far the fraction shifts left, and which biased exponent it receives. A subnormal input therefore always leaves the block as a normal single-precision number. A result register can be selected by parameter. When present, it adds one cycle and holds the last result between valid inputs.

Top module: `mfx_expand`

## Requirements
- R1: An input whose exponent field is all ones and whose fraction is zero produces exponent 0xFF and fraction 0, and keeps the input sign.
- R2: An input whose exponent and fraction fields are both zero produces 0x00000000 when the sign is 0 and 0x80000000 when the sign is 1.
- R3: An input with a zero exponent field and a nonzero fraction is handled as follows. Let p be the bit index of its highest set fraction bit, counted from 0 at the least significant bit. The result exponent is 128 - bias - (MAN_W - p). The fraction bits below p are moved to the top of the 23-bit fraction, and the remaining fraction bits are zero.
- R4: An input with exponent field e, where 0 < e < all ones, produces exponent e - bias + 127. Its fraction field is shifted left by 23 - MAN_W and fills the fraction.
- R5: An input whose exponent field is all ones and whose fraction is nonzero produces exponent 0xFF, fraction bit 22 set and fraction bits 21..0 clear, with the sign kept.
- R6: Output bit 31 always equals the input sign. The input is packed as {sign, exponent, fraction}, with the sign in the top bit.
- R7: With `OUT_REG`=1, each input accepted with `in_valid` gives exactly one result. That result appears with `out_valid` high one clock later. With `OUT_REG`=0, the result appears in the same cycle.
- R8: With `OUT_REG`=1, in a cycle after one where `in_valid` was low, `out_valid` is low and `out_word` keeps its previous value.
- R9: While `rst_n` is low, `out_valid` is 0 and `out_word` is 0.
- R10: Narrowing the output back to the compact format gives the original input code, for every code that is not a NaN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_code` as a code to convert |
| in_code | input | 1+EXP_W+MAN_W | Packed compact float {sign, exponent, fraction} |
| out_valid | output | 1 | Marks `out_word` as a fresh result |
| out_word | output | 32 | Single-precision result |

## Verification
The bench drives every code of the default format. This covers every position of the leading one in a subnormal fraction. A detector that picks the wrong bit, or that does not drop the hidden one, gives a subnormal result that is off by a power of two or carries a stray fraction bit. Codes next to the class boundaries test the exponent decode. These are the largest subnormal against the smallest normal, and the largest normal against infinity. A misplaced bias would put every normal result at the wrong exponent. The round trip would then fail for a whole band of codes, not just one. Negative zero and signed infinities test sign handling. Idle cycles between inputs test that the register holds its value and does not emit extra results.

// File: rtl/mfx_pkg.sv
package mfx_pkg;

  localparam int unsigned SP_FRAC_W = 23;
  localparam int unsigned SP_EXP_W  = 8;
  localparam int unsigned SP_BIAS   = 127;

  typedef struct packed {
    logic                  sign;
    logic [SP_EXP_W-1:0]   exp;
    logic [SP_FRAC_W-1:0]  frac;
  } sp_word_t;

  // Biased single exponent for a normal compact input.
  function automatic logic [SP_EXP_W-1:0] rebias_normal(int unsigned e_field,
                                                        int unsigned mf_bias);
    return SP_EXP_W'(e_field + SP_BIAS - mf_bias);
  endfunction

  // Biased single exponent for a subnormal whose top one sits at lead_pos.
  function automatic logic [SP_EXP_W-1:0] rebias_sub(int unsigned lead_pos,
                                                     int unsigned man_w,
                                                     int unsigned mf_bias);
    return SP_EXP_W'(SP_BIAS + 1 + lead_pos - man_w - mf_bias);
  endfunction

  // Left-align a normal fraction into the 23-bit field.
  function automatic logic [SP_FRAC_W-1:0] widen_frac(logic [SP_FRAC_W-1:0] m_low,
                                                      int unsigned man_w);
    return m_low << (SP_FRAC_W - man_w);
  endfunction

  // Push the leading one of a subnormal fraction to the hidden position
  // and keep only the bits below it.
  function automatic logic [SP_FRAC_W-1:0] sub_frac(logic [SP_FRAC_W-1:0] m_low,
                                                    int unsigned lead_pos);
    logic [SP_FRAC_W:0] t;
    t = {1'b0, m_low} << (SP_FRAC_W - lead_pos);
    return t[SP_FRAC_W-1:0];
  endfunction

endpackage

// File: rtl/mfx_field_decode.sv
module mfx_field_decode #(
  parameter int unsigned EXP_W = 4,
  parameter int unsigned MAN_W = 3,
  localparam int unsigned CODE_W = 1 + EXP_W + MAN_W
) (
  input  logic [CODE_W-1:0] code,
  output logic              sign,
  output logic [EXP_W-1:0]  exp_f,
  output logic [MAN_W-1:0]  man_f,
  output logic              f_zero,
  output logic              f_sub,
  output logic              f_norm,
  output logic              f_inf,
  output logic              f_nan
);

  logic exp_max;
  logic exp_min;
  logic man_nz;

  assign sign    = code[CODE_W-1];
  assign exp_f   = code[MAN_W +: EXP_W];
  assign man_f   = code[MAN_W-1:0];

  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign man_nz  = |man_f;

  assign f_zero  = exp_min & ~man_nz;
  assign f_sub   = exp_min &  man_nz;
  assign f_inf   = exp_max & ~man_nz;
  assign f_nan   = exp_max &  man_nz;
  assign f_norm  = ~exp_min & ~exp_max;

endmodule

// File: rtl/mfx_lead_one.sv
module mfx_lead_one #(
  parameter int unsigned W = 3,
  localparam int unsigned POS_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [POS_W-1:0] pos,
  output logic             found
);

  // Scan upward; the last set bit seen is the most significant one.
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos   = POS_W'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mfx_expand.sv
module mfx_expand #(
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned MAN_W   = 3,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned CODE_W = 1 + EXP_W + MAN_W,
  localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1,
  localparam int unsigned POS_W  = (MAN_W > 1) ? $clog2(MAN_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [31:0]       out_word
);
  import mfx_pkg::*;

  // Named internal events, observed by the bound checker.
  logic              sign;
  logic [EXP_W-1:0]  exp_f;
  logic [MAN_W-1:0]  man_f;
  logic              cls_zero, cls_sub, cls_norm, cls_inf, cls_nan;
  logic [POS_W-1:0]  lead_pos;
  logic              lead_found;
  sp_word_t          res;

  mfx_field_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_decode (
    .code   (in_code),
    .sign   (sign),
    .exp_f  (exp_f),
    .man_f  (man_f),
    .f_zero (cls_zero),
    .f_sub  (cls_sub),
    .f_norm (cls_norm),
    .f_inf  (cls_inf),
    .f_nan  (cls_nan)
  );

  mfx_lead_one #(.W(MAN_W)) u_lead (
    .vec   (man_f),
    .pos   (lead_pos),
    .found (lead_found)
  );

  always_comb begin
    res      = '0;
    res.sign = sign;
    if (cls_inf) begin
      res.exp = '1;
    end else if (cls_nan) begin
      res.exp  = '1;
      res.frac = 23'h40_0000;
    end else if (cls_sub && lead_found) begin
      res.exp  = rebias_sub(int'(lead_pos), MAN_W, BIAS);
      res.frac = sub_frac(SP_FRAC_W'(man_f), int'(lead_pos));
    end else if (cls_norm) begin
      res.exp  = rebias_normal(int'(exp_f), BIAS);
      res.frac = widen_frac(SP_FRAC_W'(man_f), MAN_W);
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_word  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_word <= res;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid & rst_n;
      assign out_word  = (in_valid & rst_n) ? res : '0;
    end
  endgenerate

endmodule

// File: rtl/mfx_expand_chk.sv
module mfx_expand_chk #(
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned MAN_W   = 3,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned CODE_W = 1 + EXP_W + MAN_W,
  localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CODE_W-1:0] in_code,
  input logic              out_valid,
  input logic [31:0]       out_word,
  input logic              cls_zero,
  input logic              cls_sub,
  input logic              cls_norm,
  input logic              cls_inf,
  input logic              cls_nan
);

  logic c_v, c_sign, c_zero, c_sub, c_norm, c_inf, c_nan;

  generate
    if (OUT_REG) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          {c_v, c_sign, c_zero, c_sub, c_norm, c_inf, c_nan} <= '0;
        end else begin
          c_v    <= in_valid;
          c_sign <= in_code[CODE_W-1];
          c_zero <= cls_zero;
          c_sub  <= cls_sub;
          c_norm <= cls_norm;
          c_inf  <= cls_inf;
          c_nan  <= cls_nan;
        end
      end
    end else begin : g_now
      assign c_v    = in_valid;
      assign c_sign = in_code[CODE_W-1];
      assign c_zero = cls_zero;
      assign c_sub  = cls_sub;
      assign c_norm = cls_norm;
      assign c_inf  = cls_inf;
      assign c_nan  = cls_nan;
    end
  endgenerate

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $countones({cls_zero, cls_sub, cls_norm, cls_inf, cls_nan}) == 1); // R4
  AST_VALID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == c_v); // R7
  AST_INF_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (c_v && c_inf) |-> out_word[30:0] == 31'h7F80_0000); // R1
  AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (c_v && c_zero) |-> out_word[30:0] == 31'h0); // R2
  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (c_v && c_sub) |-> (out_word[30:23] != 8'h00 && out_word[30:23] < 8'(128 - BIAS))); // R3
  AST_NORM_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (c_v && c_norm) |-> (out_word[22-MAN_W:0] == '0 && out_word[30:23] >= 8'(128 - BIAS))); // R4
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (c_v && c_nan) |-> (out_word[30:22] == 9'h1FF && out_word[21:0] == 22'h0)); // R5
  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    c_v |-> out_word[31] == c_sign); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && !in_valid) |=> $stable(out_word)); // R8

endmodule

bind mfx_expand mfx_expand_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_code   (in_code),
  .out_valid (out_valid),
  .out_word  (out_word),
  .cls_zero  (cls_zero),
  .cls_sub   (cls_sub),
  .cls_norm  (cls_norm),
  .cls_inf   (cls_inf),
  .cls_nan   (cls_nan)
);

// File: tb/mfx_expand_tb.sv
module mfx_expand_tb;
  localparam int E  = 4;
  localparam int S  = 3;
  localparam int CW = 1 + E + S;
  localparam int B  = (1 << (E - 1)) - 1;
  localparam int EMAX = (1 << E) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [CW-1:0] in_code = '0;
  logic          out_valid;
  logic [31:0]   out_word;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] word;
    int          code;
    string       tag;
    int          cyc;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mfx_expand #(.EXP_W(E), .MAN_W(S), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .out_word(out_word));

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Value model: magnitude = sig * 2^k, normalised until the top of a 24-bit significand.
  function automatic logic [31:0] model(int code);
    int s, e, m, k, n, fe;
    logic [23:0] sig;
    s = (code >> (CW - 1)) & 1;
    e = (code >> S) & EMAX;
    m = code & ((1 << S) - 1);
    if (e == EMAX) return (m == 0) ? {s[0], 8'hFF, 23'h0} : {s[0], 8'hFF, 23'h400000};
    if (e == 0 && m == 0) return {s[0], 31'h0};
    sig = (e == 0) ? 24'(m) : 24'((1 << S) | m);
    k = ((e == 0) ? 1 : e) - B - S;
    n = 0;
    while (!sig[23]) begin sig = sig << 1; n++; end
    fe = k - n + 23 + 127;
    return {s[0], fe[7:0], sig[22:0]};
  endfunction

  // Narrowing back to the compact format, for exact values only.
  function automatic int narrow(logic [31:0] w);
    int s, fe, k, e, m, sh;
    logic [23:0] sig;
    s = int'(w[31]);
    fe = int'(w[30:23]);
    if (fe == 255) return (s << (CW - 1)) | (EMAX << S);
    if (fe == 0) return s << (CW - 1);
    k = fe - 127;
    sig = {1'b1, w[22:0]};
    if (k >= 1 - B) begin
      e = k + B;
      m = int'(w[22:0] >> (23 - S));
    end else begin
      e = 0;
      sh = (1 - B - S) - (k - 23);
      m = int'(sig >> sh);
    end
    return (s << (CW - 1)) | (e << S) | m;
  endfunction

  function automatic string tag_of(int code);
    int e, m;
    e = (code >> S) & EMAX;
    m = code & ((1 << S) - 1);
    if (e == EMAX) return (m == 0) ? "R1" : "R5";
    if (e == 0) return (m == 0) ? "R2" : "R3";
    return "R4";
  endfunction

  task automatic send(int code);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = CW'(code);
    it.word = model(code);
    it.code = code;
    it.tag  = tag_of(code);
    it.cyc  = cyc;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_code  = '1;
  endtask

  // Monitor: pops expected items as results appear.
  initial begin
    logic [31:0] last;
    bit have_last;
    have_last = 1'b0;
    last = '0;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected result", out_word, 32'h0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(out_word == it.word, it.tag, out_word, it.word);
          check(out_word[31] == it.word[31], "R6 sign", out_word, it.word);
          check(cyc == it.cyc + 1, "R7 latency", 32'(cyc), 32'(it.cyc + 1));
          if (it.tag != "R5")
            check(narrow(out_word) == it.code, "R10 round trip",
                  32'(narrow(out_word)), 32'(it.code));
        end
        last = out_word;
        have_last = 1'b1;
      end else if (have_last) begin
        check(out_word == last, "R8 hold", out_word, last);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 valid in reset", 32'(out_valid), 32'h0);
    check(out_word == 32'h0, "R9 word in reset", out_word, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // Directed corners first: signed zeros, signed infinities, boundaries.
    send(32'h00); send(32'h80); send(32'h78); send(32'hF8);
    send(32'h01); send(32'h07); send(32'h08); send(32'h77); send(32'h79);
    idle(); idle();
    for (int c = 0; c < (1 << CW); c++) begin
      send(c);
      if (c % 9 == 4) idle();
    end
    idle(); idle(); idle();
    check(q.size() == 0, "R7 all results delivered", 32'(q.size()), 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "R7 watchdog expired", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule